// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between an execution stage and a byte-addressed 64-bit data memory port. It takes one load or store per handshake, together with the two source operand values. It decodes the instruction word and adds the sign-extended immediate to the base operand. Store immediates arrive split across the instruction word, so the unit puts them back together before the add. It then checks that the address is a multiple of the access size. A legal access goes out as a single memory request with a per-byte enable mask. Load data coming back is shifted down to byte lane zero and then sign- or zero-extended to 64 bits for writeback.

The operation input is a valid/ready stream. `op_ready` is high only while the unit is idle. An operation is taken on the clock edge where `op_valid` and `op_ready` are both high. The caller must keep the operation fields steady until that edge. The memory request is also a valid/ready stream: the unit keeps the request and all of its fields unchanged until the memory raises `mem_req_ready`. The load response is a one-cycle `mem_rsp_valid` strobe with no back-pressure. The writeback and fault outputs are one-cycle pulses.

Top module: `ldst_unit`

## Requirements
- R1: For a load, `mem_req_addr` equals `op_rs1` plus the sign extension of `instr[31:20]`.
- R2: For a load (`instr[6:0]` = 0000011), `instr[14:12]` selects the access: 000 is a signed byte, 001 a signed half, 010 a signed word, 011 a double, 100 an unsigned byte, 101 an unsigned half and 110 an unsigned word. The returned 64-bit word is shifted down by 8 × `addr[2:0]` bits. The low 1, 2 or 4 bytes are then sign- or zero-extended. A double passes through unchanged.
- R3: For a store (`instr[6:0]` = 0100011), the immediate is `{instr[31:25], instr[11:7]}`, sign-extended and added to `op_rs1`. `instr[14:12]` values 000, 001, 010 and 011 select 1, 2, 4 and 8 bytes.
- R4: `mem_req_be` bit i enables data lane `mem_req_wdata[8i+7:8i]`. The mask is (2^size − 1) shifted left by `addr[2:0]`. A store places the low 1, 2, 4 or 8 bytes of `op_rs2` at the enabled lanes and drives zero on all other lanes. `mem_req_write` is 1 for a store and 0 for a load.
- R5: When `addr` modulo the access size is nonzero, `fault_misalign` pulses for one cycle, in the cycle after the operation is taken, and `fault_addr` carries the address. No memory request is issued and `op_ready` stays high.
- R6: A load with funct3 111, a store with funct3 100–111, and any other opcode each pulse `fault_illegal` for one cycle instead of issuing a request. An illegal operation never also raises `fault_misalign`.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request and all of its fields stay unchanged in the next cycle.
- R8: Each completed load gives exactly one `wb_valid` pulse. The pulse comes in the cycle after `mem_rsp_valid`, with `wb_rd` = `instr[11:7]`. A store gives no writeback.
- R9: `op_ready` is low from the cycle after a legal operation is taken until that operation completes. A store completes when its request is accepted. A load completes when its response arrives.
- R10: After reset, `op_ready` is 1 and `mem_req_valid`, `wb_valid`, `fault_misalign` and `fault_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and able to take an operation |
| op_instr | input | 32 | Instruction word |
| op_rs1 | input | 64 | Base operand value |
| op_rs2 | input | 64 | Store data operand value |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | 64 | Byte address of the access |
| mem_req_be | output | 8 | Byte lane enables |
| mem_req_wdata | output | 64 | Store data, lane-aligned |
| mem_rsp_valid | input | 1 | Load data returned (one-cycle strobe) |
| mem_rsp_rdata | input | 64 | Aligned 64-bit word holding the load bytes |
| wb_valid | output | 1 | Writeback pulse for a completed load |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Extended load result |
| fault_misalign | output | 1 | Misaligned access pulse |
| fault_illegal | output | 1 | Illegal encoding pulse |
| fault_addr | output | 64 | Address that belongs to a fault pulse |

## Verification
Timing is counted from the edge that takes the operation:
- The request, or a fault pulse, is visible one cycle after that edge.
- The request then stays visible through any number of cycles with `mem_req_ready` low.
- The writeback pulse appears one cycle after the edge that samples `mem_rsp_valid`.

The bench drives every input one time unit after a rising edge and samples every output at the falling edge. Each handshake and pulse is therefore compared in the cycle in which it is due. The memory model stalls `mem_req_ready` on a fixed pattern and varies the response delay, so requests that must be held and several response gaps both occur. Expected requests, writebacks and faults are queued in issue order and compared one by one as they appear.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic       is_store;
    logic       is_unsigned;
    logic       illegal;
    acc_size_e  size;
    logic [11:0] imm;
    logic [4:0]  rd;
  } acc_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ldst_state_e;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [31:0] instr,
  output acc_op_t     op
);

  logic [6:0] opcode;
  logic [2:0] fn3;
  logic [9:0] unused_src_fields;

  assign opcode            = instr[6:0];
  assign fn3               = instr[14:12];
  assign unused_src_fields = instr[24:15];

  always_comb begin
    op             = '0;
    op.rd          = instr[11:7];
    op.size        = acc_size_e'(fn3[1:0]);
    if (opcode == OPC_LOAD) begin
      op.is_store    = 1'b0;
      op.imm         = instr[31:20];
      op.is_unsigned = fn3[2];
      op.illegal     = (fn3 == 3'b111);
    end else if (opcode == OPC_STORE) begin
      op.is_store    = 1'b1;
      op.imm         = {instr[31:25], instr[11:7]};
      op.is_unsigned = 1'b0;
      op.illegal     = fn3[2];
    end else begin
      op.illegal     = 1'b1;
    end
  end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   rs1,
  input  logic [XLEN-1:0]   rs2,
  input  logic [11:0]       imm,
  input  acc_size_e         size,
  output logic [XLEN-1:0]   addr,
  output logic              misaligned,
  output logic [XLEN/8-1:0] be,
  output logic [XLEN-1:0]   wdata
);

  localparam int BYTES = XLEN / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [OFF_W-1:0] off;
  logic [OFF_W:0]   nbytes;
  logic [OFF_W:0]   lo;
  logic [OFF_W:0]   hi;
  logic [XLEN-1:0]  kept;

  assign addr       = rs1 + {{(XLEN-12){imm[11]}}, imm};
  assign off        = addr[OFF_W-1:0];
  assign nbytes     = (OFF_W+1)'(1) << size;
  assign misaligned = |(off & OFF_W'(nbytes - 1'b1));
  assign lo         = {1'b0, off};
  assign hi         = lo + nbytes;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign be[i] = ((OFF_W+1)'(i) >= lo) && ((OFF_W+1)'(i) < hi);
    assign kept[8*i +: 8] = ((OFF_W+1)'(i) < nbytes) ? rs2[8*i +: 8] : 8'h00;
  end

  assign wdata = kept << {off, 3'b000};

endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
  import ldst_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]          rdata,
  input  logic [$clog2(XLEN/8)-1:0] off,
  input  acc_size_e                size,
  input  logic                     is_unsigned,
  output logic [XLEN-1:0]          result
);

  logic [XLEN-1:0] lane0;

  assign lane0 = rdata >> {off, 3'b000};

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(XLEN-8){lane0[7] & ~is_unsigned}}, lane0[7:0]};
      SZ_HALF: result = {{(XLEN-16){lane0[15] & ~is_unsigned}}, lane0[15:0]};
      SZ_WORD: result = {{(XLEN-32){lane0[31] & ~is_unsigned}}, lane0[31:0]};
      default: result = lane0;
    endcase
  end

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [31:0]       op_instr,
  input  logic [XLEN-1:0]   op_rs1,
  input  logic [XLEN-1:0]   op_rs2,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [XLEN/8-1:0] mem_req_be,
  output logic [XLEN-1:0]   mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_rdata,
  output logic              wb_valid,
  output logic [4:0]        wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              fault_misalign,
  output logic              fault_illegal,
  output logic [XLEN-1:0]   fault_addr
);

  localparam int BYTES = XLEN / 8;
  localparam int OFF_W = $clog2(BYTES);

  ldst_state_e       state;
  acc_op_t           dec;
  logic [XLEN-1:0]   ea;
  logic              mis;
  logic [BYTES-1:0]  lane_be;
  logic [XLEN-1:0]   lane_wdata;
  logic [XLEN-1:0]   ext_data;

  acc_size_e         held_size;
  logic              held_unsigned;
  logic [OFF_W-1:0]  held_off;

  ldst_decode u_decode (
    .instr (op_instr),
    .op    (dec)
  );

  ldst_agu #(.XLEN(XLEN)) u_agu (
    .rs1        (op_rs1),
    .rs2        (op_rs2),
    .imm        (dec.imm),
    .size       (dec.size),
    .addr       (ea),
    .misaligned (mis),
    .be         (lane_be),
    .wdata      (lane_wdata)
  );

  ldst_extend #(.XLEN(XLEN)) u_extend (
    .rdata       (mem_rsp_rdata),
    .off         (held_off),
    .size        (held_size),
    .is_unsigned (held_unsigned),
    .result      (ext_data)
  );

  assign op_ready      = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      mem_req_write  <= 1'b0;
      mem_req_addr   <= '0;
      mem_req_be     <= '0;
      mem_req_wdata  <= '0;
      held_size      <= SZ_BYTE;
      held_unsigned  <= 1'b0;
      held_off       <= '0;
      wb_valid       <= 1'b0;
      wb_rd          <= '0;
      wb_data        <= '0;
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
      fault_addr     <= '0;
    end else begin
      wb_valid       <= 1'b0;
      fault_misalign <= 1'b0;
      fault_illegal  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (op_valid) begin
            if (dec.illegal) begin
              fault_illegal <= 1'b1;
              fault_addr    <= ea;
            end else if (mis) begin
              fault_misalign <= 1'b1;
              fault_addr     <= ea;
            end else begin
              mem_req_write <= dec.is_store;
              mem_req_addr  <= ea;
              mem_req_be    <= lane_be;
              mem_req_wdata <= dec.is_store ? lane_wdata : '0;
              held_size     <= dec.size;
              held_unsigned <= dec.is_unsigned;
              held_off      <= ea[OFF_W-1:0];
              wb_rd         <= dec.rd;
              state         <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            state <= mem_req_write ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            wb_valid <= 1'b1;
            wb_data  <= ext_data;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_be) &&
       $stable(mem_req_wdata) && $stable(mem_req_write)));

  // R5
  fault_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_misalign |-> (!mem_req_valid && op_ready));

  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_illegal |-> (!fault_misalign && !mem_req_valid));

  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R8
  wb_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(mem_rsp_valid));

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !mem_req_valid);

  // R4
  be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_be) == 1 || $countones(mem_req_be) == 2 ||
                       $countones(mem_req_be) == 4 || $countones(mem_req_be) == 8));

endmodule

// File: tb/ldst_unit_test.sv
module ldst_unit_test;

  localparam int CLK_PERIOD = 10;

  typedef enum int { EV_REQ, EV_WB, EV_MIS, EV_ILL } ev_kind_e;
  typedef struct {
    ev_kind_e    kind;
    logic        write;
    logic [63:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
    logic [4:0]  rd;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] op_instr = '0;
  logic [63:0] op_rs1 = '0;
  logic [63:0] op_rs2 = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [63:0] mem_req_addr;
  logic [7:0]  mem_req_be;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data;
  logic        fault_misalign;
  logic        fault_illegal;
  logic [63:0] fault_addr;

  int n_checks = 0;
  int n_fails  = 0;
  ev_t exp_q[$];

  logic        rsp_pending = 1'b0;
  logic [63:0] rsp_addr = '0;
  int          rsp_delay = 0;
  int          tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_unit uut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_instr(op_instr),
    .op_rs1(op_rs1), .op_rs2(op_rs2),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .fault_misalign(fault_misalign), .fault_illegal(fault_illegal),
    .fault_addr(fault_addr)
  );

  function automatic logic [63:0] mem_word(input logic [63:0] a);
    return 64'hF1E2_D3C4_B5A6_9788 ^ {a[31:0], a[31:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: ready stalls on a fixed pattern, responses after 0..2 cycles
  initial begin
    forever begin
      @(posedge clk); #1;
      tick++;
      mem_req_ready = (tick % 3 != 1);
      mem_rsp_valid = 1'b0;
      if (rsp_pending) begin
        if (rsp_delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem_word({rsp_addr[63:3], 3'b000});
          rsp_pending   = 1'b0;
        end else begin
          rsp_delay--;
        end
      end
    end
  end

  // Monitor: pop expected events as results appear
  initial begin
    logic        stalled;
    logic [63:0] st_addr, st_wdata;
    logic [7:0]  st_be;
    ev_t e;
    stalled = 1'b0;
    st_addr = '0; st_wdata = '0; st_be = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (stalled) begin
          // R7 request held while not accepted
          check("R7 valid", {63'd0, mem_req_valid}, 64'd1);
          check("R7 addr", mem_req_addr, st_addr);
          check("R7 be", {56'd0, mem_req_be}, {56'd0, st_be});
          check("R7 wdata", mem_req_wdata, st_wdata);
        end
        stalled  = mem_req_valid && !mem_req_ready;
        st_addr  = mem_req_addr; st_be = mem_req_be; st_wdata = mem_req_wdata;
        if (mem_req_valid && mem_req_ready) begin
          if (!mem_req_write) begin
            rsp_pending = 1'b1;
            rsp_addr    = mem_req_addr;
            rsp_delay   = tick % 3;
          end
          if (exp_q.size() == 0) check("R1 unexpected request", 64'd1, 64'd0);
          else begin
            e = exp_q.pop_front();
            check("R1 request kind", {32'd0, 32'(EV_REQ)}, {32'd0, 32'(e.kind)});
            check("R1 R3 addr", mem_req_addr, e.addr);
            check("R4 write", {63'd0, mem_req_write}, {63'd0, e.write});
            check("R4 be", {56'd0, mem_req_be}, {56'd0, e.be});
            check("R4 wdata", mem_req_wdata, e.data);
          end
        end
        if (wb_valid) begin
          if (exp_q.size() == 0) check("R8 unexpected writeback", 64'd1, 64'd0);
          else begin
            e = exp_q.pop_front();
            check("R8 wb kind", {32'd0, 32'(EV_WB)}, {32'd0, 32'(e.kind)});
            check("R8 wb_rd", {59'd0, wb_rd}, {59'd0, e.rd});
            check("R2 wb_data", wb_data, e.data);
          end
        end
        if (fault_misalign) begin
          if (exp_q.size() == 0) check("R5 unexpected misalign", 64'd1, 64'd0);
          else begin
            e = exp_q.pop_front();
            check("R5 misalign kind", {32'd0, 32'(EV_MIS)}, {32'd0, 32'(e.kind)});
            check("R5 fault_addr", fault_addr, e.addr);
          end
        end
        if (fault_illegal) begin
          if (exp_q.size() == 0) check("R6 unexpected illegal", 64'd1, 64'd0);
          else begin
            e = exp_q.pop_front();
            check("R6 illegal kind", {32'd0, 32'(EV_ILL)}, {32'd0, 32'(e.kind)});
          end
        end
      end
    end
  end

  task automatic send(input logic [31:0] instr, input logic [63:0] rs1,
                      input logic [63:0] rs2, input bit busy);
    @(posedge clk); #1;
    op_valid = 1'b1; op_instr = instr; op_rs1 = rs1; op_rs2 = rs2;
    do @(negedge clk); while (!op_ready);
    @(posedge clk); #1;
    op_valid = 1'b0;
    @(negedge clk);
    // R9 busy after a legal op; R5 R6 still ready after a fault
    check(busy ? "R9 op_ready busy" : "R5 R6 op_ready after fault",
          {63'd0, op_ready}, {63'd0, !busy});
    do @(negedge clk); while (!op_ready);
  endtask

  function automatic logic [63:0] sext12(input logic [11:0] v);
    return {{52{v[11]}}, v};
  endfunction

  task automatic do_load(input logic [2:0] f3, input logic [4:0] rd,
                         input logic [63:0] rs1, input logic [11:0] imm);
    ev_t e;
    logic [63:0] a, raw, res;
    int nb;
    a  = rs1 + sext12(imm);
    nb = 1 << f3[1:0];
    e  = '{kind: EV_REQ, write: 1'b0, addr: a, be: 8'h00, data: 64'd0, rd: rd};
    if ((a % nb) != 0) begin
      e.kind = EV_MIS;
      exp_q.push_back(e);
      send({imm, 5'd1, f3, rd, 7'b0000011}, rs1, 64'd0, 1'b0);
    end else begin
      e.be = 8'((16'(1) << nb) - 1) << a[2:0];
      exp_q.push_back(e);
      raw = mem_word({a[63:3], 3'b000}) >> (8 * a[2:0]);
      case (f3)
        3'b000: res = {{56{raw[7]}}, raw[7:0]};
        3'b001: res = {{48{raw[15]}}, raw[15:0]};
        3'b010: res = {{32{raw[31]}}, raw[31:0]};
        3'b100: res = {56'd0, raw[7:0]};
        3'b101: res = {48'd0, raw[15:0]};
        3'b110: res = {32'd0, raw[31:0]};
        default: res = raw;
      endcase
      e.kind = EV_WB; e.data = res;
      exp_q.push_back(e);
      send({imm, 5'd1, f3, rd, 7'b0000011}, rs1, 64'd0, 1'b1);
    end
  endtask

  task automatic do_store(input logic [2:0] f3, input logic [63:0] rs1,
                          input logic [63:0] rs2, input logic [11:0] imm);
    ev_t e;
    logic [63:0] a, mask;
    int nb;
    a    = rs1 + sext12(imm);
    nb   = 1 << f3[1:0];
    mask = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 1);
    e    = '{kind: EV_REQ, write: 1'b1, addr: a, be: 8'h00, data: 64'd0, rd: 5'd0};
    if ((a % nb) != 0) begin
      e.kind = EV_MIS;
      exp_q.push_back(e);
      send({imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011}, rs1, rs2, 1'b0);
    end else begin
      e.be   = 8'((16'(1) << nb) - 1) << a[2:0];
      e.data = (rs2 & mask) << (8 * a[2:0]);
      exp_q.push_back(e);
      send({imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011}, rs1, rs2, 1'b1);
    end
  endtask

  task automatic do_illegal(input logic [31:0] instr);
    ev_t e;
    e = '{kind: EV_ILL, write: 1'b0, addr: 64'd0, be: 8'h00, data: 64'd0, rd: 5'd0};
    exp_q.push_back(e);
    send(instr, 64'h1000, 64'd0, 1'b0);
  endtask

  task automatic run_tests();
    // R10 reset state
    check("R10 op_ready", {63'd0, op_ready}, 64'd1);
    check("R10 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    check("R10 wb_valid", {63'd0, wb_valid}, 64'd0);
    check("R10 faults", {62'd0, fault_misalign, fault_illegal}, 64'd0);
    // R2 each load width and sign, several lanes; R1 negative immediate
    do_load(3'b000, 5'd3, 64'h1000, 12'h003);
    do_load(3'b100, 5'd4, 64'h1000, 12'h007);
    do_load(3'b001, 5'd5, 64'h2010, 12'hFFA);
    do_load(3'b101, 5'd6, 64'h2000, 12'h006);
    do_load(3'b010, 5'd7, 64'h3004, 12'h000);
    do_load(3'b110, 5'd8, 64'h3000, 12'h004);
    do_load(3'b011, 5'd9, 64'h4008, 12'hFF8);
    do_load(3'b010, 5'd10, 64'h0000_0000_8000_0000, 12'h7F0);
    // R3 R4 store widths and lanes
    do_store(3'b000, 64'h5000, 64'hDEAD_BEEF_CAFE_F00D, 12'h005);
    do_store(3'b001, 64'h5010, 64'h1122_3344_5566_7788, 12'hFF2);
    do_store(3'b010, 64'h5000, 64'h8877_6655_4433_2211, 12'h804);
    do_store(3'b011, 64'h6000, 64'h0123_4567_89AB_CDEF, 12'h010);
    // R5 misaligned accesses
    do_load(3'b001, 5'd11, 64'h7000, 12'h001);
    do_store(3'b010, 64'h7000, 64'h55, 12'h002);
    do_load(3'b011, 5'd12, 64'h7004, 12'h000);
    // R6 illegal encodings
    do_illegal({12'h000, 5'd1, 3'b111, 5'd2, 7'b0000011});
    do_illegal({7'h00, 5'd2, 5'd1, 3'b100, 5'd0, 7'b0100011});
    do_illegal({12'h001, 5'd1, 3'b011, 5'd2, 7'b0010011});
    // back to normal after faults
    do_load(3'b000, 5'd31, 64'h1000, 12'h006);
    repeat (6) @(negedge clk);
    check("R8 all results observed", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule